// File: doc/BRIEF.md
# Display Fetch Queue with Urgent Refill Threshold

This block buffers display words between a memory controller and a display output stage. Burst reads from memory push 64-bit words into a queue that holds 64 of them. Each word carries one tag bit that marks it as a pixel word or a cursor pattern word. The output stage pops words at its own rate and gets data and tag together, one cycle after the pop.

The queue tracks its fill level and compares it against a threshold set by software. It drives two refill requests to the memory arbiter:
- A normal request while the level is at or above the threshold and space remains. The arbiter serves it when nothing else is pending.
- An urgent request while the level is below the threshold. The arbiter ranks it above every other requestor, because display data is needed in real time.

Two sticky error flags catch misuse:
- Underflow: a pop on an empty queue sets it.
- Overflow: a push into a full queue sets it.

Each flag has its own clear pulse.

Top module: `dfetch_queue`

## Requirements
- R1: After reset, `level_o` is 0, both error flags are 0 and `rd_data_o`/`rd_cursor_o` are 0. `urgent_o` is 1 if and only if `thresh_i` is nonzero.
- R2: Words leave in the order they were accepted. After a pop is accepted at a clock edge, `rd_data_o` shows the oldest word from that edge until the next accepted pop.
- R3: The tag given on `wr_cursor_i` (1 = cursor pattern word, 0 = pixel word) appears on `rd_cursor_o` together with its data word.
- R4: An accepted push raises `level_o` by one and an accepted pop lowers it by one. When both are accepted at the same edge, the level stays unchanged.
- R5: `urgent_o` is 1 exactly when `level_o` < `thresh_i` (`thresh_i` is unsigned, 6 bits).
- R6: `req_o` is 1 exactly when `level_o` >= `thresh_i` and `level_o` < 64. `req_o` and `urgent_o` are never both 1.
- R7: The queue accepts 64 words. A push while `level_o` is 64 is dropped, even if a pop happens at the same edge. The dropped push leaves the stored words unchanged and sets `overflow_o`, which then stays set.
- R8: A pop while `level_o` is 0 sets `underflow_o`, which then stays set. Such a pop leaves `rd_data_o` and `rd_cursor_o` at the last valid word. A push at the same edge is still accepted.
- R9: A one-cycle pulse on `clr_underflow_i` or `clr_overflow_i` clears the matching flag at that edge. If a new error occurs at the same edge, the flag stays set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Push a word from memory |
| wr_data_i | input | 64 | Word to push |
| wr_cursor_i | input | 1 | Tag of pushed word: 1 cursor, 0 pixel |
| rd_en_i | input | 1 | Pop a word for the display |
| rd_data_o | output | 64 | Popped word (registered) |
| rd_cursor_o | output | 1 | Tag of popped word |
| thresh_i | input | 6 | Urgent-refill threshold |
| level_o | output | 7 | Number of stored words |
| req_o | output | 1 | Normal-priority refill request |
| urgent_o | output | 1 | Urgent refill request |
| underflow_o | output | 1 | Sticky: pop on empty |
| overflow_o | output | 1 | Sticky: push on full |
| clr_underflow_i | input | 1 | Clear pulse for underflow_o |
| clr_overflow_i | input | 1 | Clear pulse for overflow_o |

## Verification
The assertions assume that `thresh_i` holds its value across each push/pop edge. They also assume that clear pulses last one cycle and never coincide with a check that expects the flag to stay set. The stimulus changes the threshold only between phases, and it only issues clears on cycles whose expected flag values the bench models explicitly. The random phases are biased toward pushes, toward pops, or balanced, so that the level reaches both 0 and 64. Overflow, underflow and simultaneous-operation cases at the edges are also driven directly.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
  typedef enum logic {
    TAG_PIXEL  = 1'b0,
    TAG_CURSOR = 1'b1
  } word_tag_e;

  function automatic int unsigned ptr_bits(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/dfetch_store.sv
module dfetch_store #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = dfetch_pkg::ptr_bits(DEPTH),
  localparam int unsigned ENT_W = WIDTH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ok_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [ENT_W-1:0] wr_word_i,
  input  logic             rd_ok_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic [ENT_W-1:0] rd_word_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok_i) mem_q[wr_ptr_i] <= wr_word_i;
  end

  // output register holds last valid word on a refused pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_ok_i) rd_q <= mem_q[rd_ptr_i];
  end

  assign rd_word_o = rd_q;
endmodule

// File: rtl/dfetch_level.sv
module dfetch_level #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = dfetch_pkg::ptr_bits(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             clr_ufl_i,
  input  logic             clr_ofl_i,
  output logic             wr_ok_o,
  output logic             rd_ok_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ufl_o,
  output logic             ofl_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic             ufl_q, ofl_q;
  logic             full, empty, wr_ok, rd_ok;

  assign full  = (lvl_q == LVL_FULL);
  assign empty = (lvl_q == '0);
  assign wr_ok = wr_en_i && !full;
  assign rd_ok = rd_en_i && !empty;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
      ufl_q    <= 1'b0;
      ofl_q    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (wr_ok && !rd_ok)      lvl_q <= lvl_q + LVL_W'(1);
      else if (rd_ok && !wr_ok) lvl_q <= lvl_q - LVL_W'(1);
      // set beats clear
      if (rd_en_i && empty)  ufl_q <= 1'b1;
      else if (clr_ufl_i)    ufl_q <= 1'b0;
      if (wr_en_i && full)   ofl_q <= 1'b1;
      else if (clr_ofl_i)    ofl_q <= 1'b0;
    end
  end

  assign wr_ok_o  = wr_ok;
  assign rd_ok_o  = rd_ok;
  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign level_o  = lvl_q;
  assign ufl_o    = ufl_q;
  assign ofl_o    = ofl_q;
endmodule

// File: rtl/dfetch_req.sv
module dfetch_req #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned TH_W  = dfetch_pkg::ptr_bits(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [TH_W-1:0]  thresh_i,
  output logic             req_o,
  output logic             urgent_o
);
  logic below, has_room;

  assign below    = level_i < LVL_W'(thresh_i);
  assign has_room = level_i < LVL_W'(DEPTH);
  assign urgent_o = below;
  assign req_o    = !below && has_room;
endmodule

// File: rtl/dfetch_queue.sv
module dfetch_queue #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = dfetch_pkg::ptr_bits(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             wr_cursor_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_cursor_o,
  input  logic [PTR_W-1:0] thresh_i,
  output logic [LVL_W-1:0] level_o,
  output logic             req_o,
  output logic             urgent_o,
  output logic             underflow_o,
  output logic             overflow_o,
  input  logic             clr_underflow_i,
  input  logic             clr_overflow_i
);
  import dfetch_pkg::*;

  logic             wr_ok, rd_ok;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  logic [WIDTH:0]   rd_word;
  word_tag_e        wr_tag;

  assign wr_tag = wr_cursor_i ? TAG_CURSOR : TAG_PIXEL;

  dfetch_level #(.DEPTH(DEPTH)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .clr_ufl_i (clr_underflow_i),
    .clr_ofl_i (clr_overflow_i),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .level_o   (level),
    .ufl_o     (underflow_o),
    .ofl_o     (overflow_o)
  );

  dfetch_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ok_i   (wr_ok),
    .wr_ptr_i  (wr_ptr),
    .wr_word_i ({wr_tag, wr_data_i}),
    .rd_ok_i   (rd_ok),
    .rd_ptr_i  (rd_ptr),
    .rd_word_o (rd_word)
  );

  dfetch_req #(.DEPTH(DEPTH)) u_req (
    .level_i  (level),
    .thresh_i (thresh_i),
    .req_o    (req_o),
    .urgent_o (urgent_o)
  );

  assign level_o     = level;
  assign rd_data_o   = rd_word[WIDTH-1:0];
  assign rd_cursor_o = rd_word[WIDTH];
endmodule

// File: rtl/dfetch_queue_chk.sv
module dfetch_queue_chk #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = dfetch_pkg::ptr_bits(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             rd_cursor_o,
  input logic [PTR_W-1:0] thresh_i,
  input logic [LVL_W-1:0] level_o,
  input logic             req_o,
  input logic             urgent_o,
  input logic             underflow_o,
  input logic             overflow_o,
  input logic             clr_underflow_i,
  input logic             clr_overflow_i
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  a_r6_req_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o, urgent_o}));

  a_r7_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL);

  a_r6_full_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == FULL) |-> (!req_o && !urgent_o));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == FULL && wr_en_i && !rd_en_i) |=> (level_o == FULL && overflow_o));

  a_r8_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0 && rd_en_i) |=>
      (underflow_o && $stable(rd_data_o) && $stable(rd_cursor_o)));

  a_r4_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && level_o != '0 && level_o != FULL) |=> $stable(level_o));

  a_r9_ufl_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !clr_underflow_i) |=> underflow_o);

  a_r9_ofl_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr_overflow_i) |=> overflow_o);

  a_r5_urgent_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && $stable(thresh_i) && !wr_en_i) |=> urgent_o);
endmodule

bind dfetch_queue dfetch_queue_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .rd_en_i         (rd_en_i),
  .rd_data_o       (rd_data_o),
  .rd_cursor_o     (rd_cursor_o),
  .thresh_i        (thresh_i),
  .level_o         (level_o),
  .req_o           (req_o),
  .urgent_o        (urgent_o),
  .underflow_o     (underflow_o),
  .overflow_o      (overflow_o),
  .clr_underflow_i (clr_underflow_i),
  .clr_overflow_i  (clr_overflow_i)
);

// File: tb/dfetch_queue_tb.sv
`timescale 1ns/1ps
module dfetch_queue_tb;
  localparam int W = 64;
  localparam int D = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_cur = 1'b0, rd_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [5:0]    thresh = 6'd16;
  logic          clr_u = 1'b0, clr_o = 1'b0;
  logic [W-1:0]  rd_data;
  logic          rd_cur, req, urg, ufl, ofl;
  logic [6:0]    level;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [W:0] mq [D];
  int         head = 0, cnt = 0;
  logic [W:0] exp_rd = '0;
  logic       exp_ufl = 0, exp_ofl = 0;

  always #2.5 clk = ~clk;

  dfetch_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_cursor_i(wr_cur), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_cursor_o(rd_cur), .thresh_i(thresh), .level_o(level), .req_o(req),
    .urgent_o(urg), .underflow_o(ufl), .overflow_o(ofl),
    .clr_underflow_i(clr_u), .clr_overflow_i(clr_o)
  );

  function automatic bit f_urgent(int lv, int th);
    return lv < th;
  endfunction
  function automatic bit f_req(int lv, int th);
    return (lv >= th) && (lv < D);
  endfunction

  task automatic chk(string tag, logic [W:0] act, logic [W:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4 level", 65'(level), 65'(cnt));
    chk("R5 urgent", 65'(urg), 65'(f_urgent(cnt, thresh)));
    chk("R6 req", 65'(req), 65'(f_req(cnt, thresh)));
    chk("R8 underflow flag", 65'(ufl), 65'(exp_ufl));
    chk("R7 overflow flag", 65'(ofl), 65'(exp_ofl));
    chk("R2 R3 read word", {rd_cur, rd_data}, exp_rd);
  endtask

  // drive after negedge, model the edge, sample 1 ns after posedge
  task automatic step(bit w, logic [W-1:0] d, bit c, bit r, bit cu, bit co);
    int tail;
    bit wok, rok;
    wr_en = w; wr_data = d; wr_cur = c; rd_en = r; clr_u = cu; clr_o = co;
    @(posedge clk);
    #1;
    wok = w && cnt < D;
    rok = r && cnt > 0;
    tail = (head + cnt) % D;
    if (r && cnt == 0) exp_ufl = 1; else if (cu) exp_ufl = 0;
    if (w && cnt == D) exp_ofl = 1; else if (co) exp_ofl = 0;
    if (rok) begin exp_rd = mq[head]; head = (head + 1) % D; end
    if (wok) mq[tail] = {c, d};
    cnt = cnt + int'(wok) - int'(rok);
    check_all();
    @(negedge clk);
    wr_en = 0; rd_en = 0; clr_u = 0; clr_o = 0;
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0d15));
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", 65'(level), 65'd0);
    chk("R1 flags", 65'({ufl, ofl}), 65'd0);
    chk("R1 read word", {rd_cur, rd_data}, '0);
    chk("R1 urgent", 65'(urg), 65'd1);
    thresh = 6'd0; #1;
    chk("R1 urgent zero thresh", 65'(urg), 65'd0);
    chk("R6 req zero thresh", 65'(req), 65'd1);
    thresh = 6'd20;

    // R8 read on empty before any data, with simultaneous push
    step(0, '0, 0, 1, 0, 0);
    step(1, 64'h1111_2222_3333_4444, 1, 1, 0, 0);
    // R9 clear while new underflow at same edge keeps it set
    step(0, '0, 0, 1, 1, 0);       // level 1 -> pop accepted, clear applies
    step(0, '0, 0, 1, 1, 0);       // empty pop + clear: stays set
    step(0, '0, 0, 0, 1, 0);       // clear alone
    chk("R9 underflow cleared", 65'(ufl), 65'd0);

    // R7 fill to capacity with alternating tags, R5/R6 crossing threshold
    for (int i = 0; i < D; i++) step(1, rnd64(), i[0], 0, 0, 0);
    chk("R7 full level", 65'(level), 65'd64);
    step(1, 64'hdead_beef_dead_beef, 1, 0, 0, 0);  // dropped
    step(1, 64'hbad0_bad0_bad0_bad0, 0, 1, 0, 0);  // dropped, pop accepted
    step(0, '0, 0, 0, 0, 1);
    chk("R9 overflow cleared", 65'(ofl), 65'd0);
    // drain fully: model verifies dropped words never appear (R7, R2)
    for (int i = 0; i < D; i++) step(0, '0, 0, 1, 0, 0);
    step(0, '0, 0, 1, 0, 0);       // R8 held word
    step(0, '0, 0, 0, 1, 0);

    // R4 simultaneous push and pop mid-level
    for (int i = 0; i < 10; i++) step(1, rnd64(), 0, 0, 0, 0);
    for (int i = 0; i < 8; i++)  step(1, rnd64(), i[1], 1, 0, 0);

    // random phases: fill-biased, drain-biased, balanced
    for (int ph = 0; ph < 6; ph++) begin
      int pw, pr;
      thresh = 6'($urandom_range(0, 63));
      pw = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 25 : 50;
      pr = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 80 : 50;
      for (int k = 0; k < 400; k++) begin
        bit w, r, cu, co;
        w  = ($urandom_range(0, 99) < pw);
        r  = ($urandom_range(0, 99) < pr);
        cu = ($urandom_range(0, 99) < 5);
        co = ($urandom_range(0, 99) < 5);
        step(w, rnd64(), 1'($urandom()), r, cu, co);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule